// File: doc/BRIEF.md
# Guarded Access Steering Unit

This unit sits beside one core that has both an L1 data cache and a local scratchpad. It decides where each memory access goes. Every access arrives with a class tag. Strided accesses go to the local scratchpad. Random accesses go to the cache port. Guarded accesses may alias data that currently lives in some scratchpad, so the unit resolves them before they leave.

The unit resolves a guarded access with two local tables. The first is a small directory. It maps regular 64-byte blocks to blocks of the local scratchpad. The second is a negative filter. It holds blocks known to be held by no scratchpad anywhere. A directory hit sends the access to the local scratchpad at the translated address. A filter hit sends it to the cache unchanged. When both tables miss, the unit asks a remote lookup port and stalls until the answer returns. A remote hit sends the access to the remote scratchpad. A remote miss sends it to the cache and records the block in the filter.

When software maps a block into the local scratchpad, it drives the map port. The directory takes the new mapping, and any filter entry for that block is dropped. Scratchpad transfers, the cache and the global filter directory lie outside the unit; they appear only as ports.

Top module: `gsu_steer`

## Requirements
- R1: Reset state. After reset, out_valid and rl_req_valid are 0 and req_ready is 1. The directory and the filter are empty, so the first guarded access of any block raises a remote lookup.
- R2: Strided accesses (class 2'b00). A strided access accepted in cycle N is dispatched in cycle N+1 with out_dest 2'b00 (local scratchpad). out_addr equals req_addr, and out_we equals req_we.
- R3: Random accesses (class 2'b01, and also the unused code 2'b11). These are dispatched one cycle after acceptance with out_dest 2'b01 (cache), with the address unchanged.
- R4: Directory hit. A guarded access (class 2'b10) whose block (address bits above bit 5) hits the directory is dispatched one cycle later with out_dest 2'b00. Its out_addr is the stored scratchpad block shifted left by 6, OR the access's low 6 bits, zero-extended.
- R5: Filter hit. A guarded access that misses the directory but hits the filter is dispatched one cycle later with out_dest 2'b01, with its address unchanged and no remote request.
- R6: Remote lookup request and stall. When both tables miss, rl_req_valid pulses high for exactly one cycle, one cycle after acceptance, with rl_req_addr equal to the block-aligned address. While a lookup is outstanding, req_ready is 0 for every class. It returns to 1 in the cycle after rl_rsp_valid.
- R7: Remote hit. A response with rl_rsp_hit=1 produces a dispatch in the following cycle. That dispatch has out_dest 2'b10, out_core equal to rl_rsp_core, and out_addr equal to rl_rsp_spm_blk shifted left by 6, OR the offset of the stalled access.
- R8: Remote miss. A response with rl_rsp_hit=0 dispatches the stalled access to the cache (2'b01) with its address unchanged. It also inserts the block into the filter, so a later guarded access to that block follows R5.
- R9: Mapping. A map_valid cycle writes map_blk to map_spm_blk into the directory. If that block is already present, its entry is overwritten. Any filter entry holding that block is invalidated.
- R10: Filter replacement. On insert, the first invalid entry is used. If no entry is invalid, the first entry whose use bit is clear is used. A hit or an insert sets the entry's use bit. When that leaves every use bit set, all other use bits are cleared.
- R11: Directory replacement. A new block goes to the first free entry. When no entry is free, it goes to the entry named by a round-robin pointer. The pointer starts at 0 and advances only on such a replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit can accept an access |
| req_class | input | 2 | 00 strided, 01 random, 10 guarded, 11 random |
| req_addr | input | ADDR_W | Access address |
| req_we | input | 1 | Access is a store |
| map_valid | input | 1 | Install a scratchpad mapping |
| map_blk | input | ADDR_W-6 | Regular block number being mapped |
| map_spm_blk | input | SPM_AW-6 | Local scratchpad block receiving it |
| out_valid | output | 1 | Dispatch valid |
| out_dest | output | 2 | 00 local scratchpad, 01 cache, 10 remote scratchpad |
| out_addr | output | ADDR_W | Dispatched address |
| out_core | output | CORE_W | Remote core for destination 10, else 0 |
| out_we | output | 1 | Dispatched store flag |
| rl_req_valid | output | 1 | Remote lookup request |
| rl_req_addr | output | ADDR_W | Block-aligned lookup address |
| rl_rsp_valid | input | 1 | Remote lookup response |
| rl_rsp_hit | input | 1 | Some remote scratchpad holds the block |
| rl_rsp_core | input | CORE_W | Core holding the block |
| rl_rsp_spm_blk | input | SPM_AW-6 | Block inside that scratchpad |

## Verification
The hardest states to reach from the ports are the two replacement corners. In the first, the filter is completely full with one use bit freshly set. In the second, the directory is full and its round-robin victim is a block that was earlier filtered, then remapped. The stimulus drives 48 distinct remote misses to fill the filter and retouches its oldest entry. It then inserts one more block and probes which block now raises a remote request. The directory case uses the same probing: 33 mappings, with the first block remapped in place. A behavioural model written in the bench tracks both tables and is compared with every output on every clock.

// File: rtl/gsu_pkg.sv
package gsu_pkg;

    typedef enum logic [1:0] {
        CL_STRIDE = 2'b00,
        CL_RANDOM = 2'b01,
        CL_GUARD  = 2'b10,
        CL_SPARE  = 2'b11
    } acc_class_e;

    typedef enum logic [1:0] {
        DST_LSPM  = 2'b00,
        DST_CACHE = 2'b01,
        DST_RSPM  = 2'b10
    } dest_e;

    // Destination of a class that needs no table lookup
    function automatic dest_e plain_dest(acc_class_e c);
        return (c == CL_STRIDE) ? DST_LSPM : DST_CACHE;
    endfunction

endpackage

// File: rtl/gsu_dir.sv
module gsu_dir #(
    parameter int TAG_W = 26,
    parameter int SPM_W = 9,
    parameter int N     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [SPM_W-1:0] lk_spm,
    input  logic             map_en,
    input  logic [TAG_W-1:0] map_tag,
    input  logic [SPM_W-1:0] map_spm
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld;
    logic [TAG_W-1:0] tag [N];
    logic [SPM_W-1:0] spm [N];
    logic [IW-1:0]    rr;

    logic          same_f, free_f;
    logic [IW-1:0] same_i, free_i, wr_i;

    always_comb begin
        lk_hit = 1'b0;
        lk_spm = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && tag[i] == lk_tag) begin
                lk_hit = 1'b1;
                lk_spm = spm[i];
            end
        end
    end

    always_comb begin
        same_f = 1'b0;
        free_f = 1'b0;
        same_i = '0;
        free_i = '0;
        for (int i = 0; i < N; i++) begin
            if (!same_f && vld[i] && tag[i] == map_tag) begin
                same_f = 1'b1;
                same_i = IW'(i);
            end
            if (!free_f && !vld[i]) begin
                free_f = 1'b1;
                free_i = IW'(i);
            end
        end
        wr_i = same_f ? same_i : (free_f ? free_i : rr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            rr  <= '0;
        end else if (map_en) begin
            vld[wr_i] <= 1'b1;
            tag[wr_i] <= map_tag;
            spm[wr_i] <= map_spm;
            if (!same_f && !free_f)
                rr <= (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
        end
    end

endmodule

// File: rtl/gsu_filter.sv
module gsu_filter #(
    parameter int TAG_W = 26,
    parameter int N     = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_en,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld, use_b, vld_n, use_n;
    logic [TAG_W-1:0] tag [N];
    logic [TAG_W-1:0] tag_n [N];
    logic [IW-1:0]    hit_i, vic_i;

    function automatic logic [N-1:0] touch(logic [N-1:0] u, logic [IW-1:0] idx);
        logic [N-1:0] r;
        r = u;
        r[idx] = 1'b1;
        if (&r) begin
            r = '0;
            r[idx] = 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        lk_hit = 1'b0;
        hit_i  = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && tag[i] == lk_tag) begin
                lk_hit = 1'b1;
                hit_i  = IW'(i);
            end
        end
    end

    always_comb begin
        logic inv_f, old_f;
        inv_f = 1'b0;
        old_f = 1'b0;
        vic_i = '0;
        for (int i = 0; i < N; i++) begin
            if (!inv_f && !vld[i]) begin
                inv_f = 1'b1;
                vic_i = IW'(i);
            end
        end
        if (!inv_f) begin
            for (int i = 0; i < N; i++) begin
                if (!old_f && !use_b[i]) begin
                    old_f = 1'b1;
                    vic_i = IW'(i);
                end
            end
        end
    end

    always_comb begin
        vld_n = vld;
        use_n = use_b;
        tag_n = tag;
        if (lk_en && lk_hit)
            use_n = touch(use_n, hit_i);
        if (ins_en) begin
            vld_n[vic_i] = 1'b1;
            tag_n[vic_i] = ins_tag;
            use_n = touch(use_n, vic_i);
        end
        if (inv_en) begin
            for (int i = 0; i < N; i++) begin
                if (vld_n[i] && tag_n[i] == inv_tag) begin
                    vld_n[i] = 1'b0;
                    use_n[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= '0;
            use_b <= '0;
        end else begin
            vld   <= vld_n;
            use_b <= use_n;
        end
        tag <= tag_n;
    end

endmodule

// File: rtl/gsu_steer.sv
module gsu_steer
    import gsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 6,
    parameter int SPM_AW = 15,
    parameter int CORE_W = 6,
    parameter int DIR_N  = 32,
    parameter int FLT_N  = 48
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_class,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_we,
    input  logic                      map_valid,
    input  logic [ADDR_W-BLK_W-1:0]   map_blk,
    input  logic [SPM_AW-BLK_W-1:0]   map_spm_blk,
    output logic                      out_valid,
    output logic [1:0]                out_dest,
    output logic [ADDR_W-1:0]         out_addr,
    output logic [CORE_W-1:0]         out_core,
    output logic                      out_we,
    output logic                      rl_req_valid,
    output logic [ADDR_W-1:0]         rl_req_addr,
    input  logic                      rl_rsp_valid,
    input  logic                      rl_rsp_hit,
    input  logic [CORE_W-1:0]         rl_rsp_core,
    input  logic [SPM_AW-BLK_W-1:0]   rl_rsp_spm_blk
);
    localparam int TAG_W = ADDR_W - BLK_W;
    localparam int SPM_W = SPM_AW - BLK_W;
    localparam int PAD_W = ADDR_W - SPM_AW;

    acc_class_e        cls;
    logic              accept, guard_acc, rsp_take;
    logic              dir_hit, flt_hit;
    logic [SPM_W-1:0]  dir_spm;
    logic              wait_q;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_we;

    dest_e             dest_q;
    logic              ov_q, rl_q, we_q;
    logic [ADDR_W-1:0] oaddr_q, rladdr_q;
    logic [CORE_W-1:0] core_q;

    assign cls       = acc_class_e'(req_class);
    assign req_ready = !wait_q;
    assign accept    = req_valid && !wait_q;
    assign guard_acc = accept && (cls == CL_GUARD);
    assign rsp_take  = wait_q && rl_rsp_valid;

    gsu_dir #(.TAG_W(TAG_W), .SPM_W(SPM_W), .N(DIR_N)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .lk_tag  (req_addr[ADDR_W-1:BLK_W]),
        .lk_hit  (dir_hit),
        .lk_spm  (dir_spm),
        .map_en  (map_valid),
        .map_tag (map_blk),
        .map_spm (map_spm_blk)
    );

    gsu_filter #(.TAG_W(TAG_W), .N(FLT_N)) u_flt (
        .clk     (clk),
        .rst     (rst),
        .lk_en   (guard_acc),
        .lk_tag  (req_addr[ADDR_W-1:BLK_W]),
        .lk_hit  (flt_hit),
        .ins_en  (rsp_take && !rl_rsp_hit),
        .ins_tag (pend_addr[ADDR_W-1:BLK_W]),
        .inv_en  (map_valid),
        .inv_tag (map_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q    <= 1'b0;
            ov_q      <= 1'b0;
            rl_q      <= 1'b0;
            dest_q    <= DST_LSPM;
            oaddr_q   <= '0;
            rladdr_q  <= '0;
            core_q    <= '0;
            we_q      <= 1'b0;
            pend_addr <= '0;
            pend_we   <= 1'b0;
        end else begin
            ov_q <= 1'b0;
            rl_q <= 1'b0;
            if (accept) begin
                core_q <= '0;
                we_q   <= req_we;
                if (cls != CL_GUARD) begin
                    ov_q    <= 1'b1;
                    dest_q  <= plain_dest(cls);
                    oaddr_q <= req_addr;
                end else if (dir_hit) begin
                    ov_q    <= 1'b1;
                    dest_q  <= DST_LSPM;
                    oaddr_q <= {{PAD_W{1'b0}}, dir_spm, req_addr[BLK_W-1:0]};
                end else if (flt_hit) begin
                    ov_q    <= 1'b1;
                    dest_q  <= DST_CACHE;
                    oaddr_q <= req_addr;
                end else begin
                    rl_q      <= 1'b1;
                    rladdr_q  <= {req_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
                    wait_q    <= 1'b1;
                    pend_addr <= req_addr;
                    pend_we   <= req_we;
                end
            end else if (rsp_take) begin
                wait_q <= 1'b0;
                ov_q   <= 1'b1;
                we_q   <= pend_we;
                if (rl_rsp_hit) begin
                    dest_q  <= DST_RSPM;
                    core_q  <= rl_rsp_core;
                    oaddr_q <= {{PAD_W{1'b0}}, rl_rsp_spm_blk, pend_addr[BLK_W-1:0]};
                end else begin
                    dest_q  <= DST_CACHE;
                    core_q  <= '0;
                    oaddr_q <= pend_addr;
                end
            end
        end
    end

    assign out_valid    = ov_q;
    assign out_dest     = dest_q;
    assign out_addr     = oaddr_q;
    assign out_core     = core_q;
    assign out_we       = we_q;
    assign rl_req_valid = rl_q;
    assign rl_req_addr  = rladdr_q;

endmodule

// File: rtl/gsu_steer_chk.sv
module gsu_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_class,
    input logic       out_valid,
    input logic [1:0] out_dest,
    input logic       rl_req_valid,
    input logic       rl_rsp_valid,
    input logic       rl_rsp_hit
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r2_strided_local: assert property (@(posedge clk) disable iff (rst)
        (acc && req_class == 2'b00) |=> (out_valid && out_dest == 2'b00));

    a_r3_random_cache: assert property (@(posedge clk) disable iff (rst)
        (acc && req_class[0]) |=> (out_valid && out_dest == 2'b01));

    a_r6_guard_answers: assert property (@(posedge clk) disable iff (rst)
        (acc && req_class == 2'b10) |=> (out_valid || rl_req_valid));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rl_req_valid |=> !rl_req_valid);

    a_r6_stall: assert property (@(posedge clk) disable iff (rst)
        rl_req_valid |-> (!req_ready && !out_valid));

    a_r7_remote_dispatch: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && rl_rsp_valid && rl_rsp_hit) |=> (out_valid && out_dest == 2'b10 && req_ready));

    a_r8_miss_to_cache: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && rl_rsp_valid && !rl_rsp_hit) |=> (out_valid && out_dest == 2'b01 && req_ready));

endmodule

bind gsu_steer gsu_steer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_class    (req_class),
    .out_valid    (out_valid),
    .out_dest     (out_dest),
    .rl_req_valid (rl_req_valid),
    .rl_rsp_valid (rl_rsp_valid),
    .rl_rsp_hit   (rl_rsp_hit)
);

// File: tb/gsu_steer_bench.sv
`timescale 1ns/1ps
module gsu_steer_bench;
    localparam int AW = 32, CW = 6, SW = 9, TW = 26, DN = 32, FN = 48;

    logic          clk = 1'b0, rst = 1'b1;
    logic          req_valid = 0, req_we = 0, map_valid = 0;
    logic [1:0]    req_class = 0;
    logic [AW-1:0] req_addr = 0;
    logic [TW-1:0] map_blk = 0;
    logic [SW-1:0] map_spm_blk = 0, rl_rsp_spm_blk = 0;
    logic          rl_rsp_valid = 0, rl_rsp_hit = 0;
    logic [CW-1:0] rl_rsp_core = 0;
    logic          req_ready, out_valid, out_we, rl_req_valid;
    logic [1:0]    out_dest;
    logic [AW-1:0] out_addr, rl_req_addr;
    logic [CW-1:0] out_core;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gsu_steer u_gsu_steer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_class(req_class), .req_addr(req_addr), .req_we(req_we),
        .map_valid(map_valid), .map_blk(map_blk), .map_spm_blk(map_spm_blk),
        .out_valid(out_valid), .out_dest(out_dest), .out_addr(out_addr),
        .out_core(out_core), .out_we(out_we), .rl_req_valid(rl_req_valid),
        .rl_req_addr(rl_req_addr), .rl_rsp_valid(rl_rsp_valid),
        .rl_rsp_hit(rl_rsp_hit), .rl_rsp_core(rl_rsp_core),
        .rl_rsp_spm_blk(rl_rsp_spm_blk)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          d_v [DN];
    logic [TW-1:0] d_t [DN];
    logic [SW-1:0] d_s [DN];
    int          d_rr;
    bit          f_v [FN];
    bit          f_u [FN];
    logic [TW-1:0] f_t [FN];
    bit          m_wait;
    logic [AW-1:0] m_pa;
    logic        m_pwe;
    bit          e_ov, e_rl, e_we;
    logic [1:0]  e_dest;
    logic [AW-1:0] e_addr, e_rla;
    logic [CW-1:0] e_core;
    string       e_tag = "R1";

    function automatic int dir_find(logic [TW-1:0] t);
        for (int i = 0; i < DN; i++) if (d_v[i] && d_t[i] == t) return i;
        return -1;
    endfunction

    function automatic int flt_find(logic [TW-1:0] t);
        for (int i = 0; i < FN; i++) if (f_v[i] && f_t[i] == t) return i;
        return -1;
    endfunction

    task automatic flt_touch(int k);
        bit all;
        f_u[k] = 1;
        all = 1;
        for (int i = 0; i < FN; i++) if (!f_u[i]) all = 0;
        if (all) for (int i = 0; i < FN; i++) f_u[i] = (i == k);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (d_v[i]) d_v[i] = 0;
            foreach (f_v[i]) begin f_v[i] = 0; f_u[i] = 0; end
            d_rr = 0; m_wait = 0; e_ov = 0; e_rl = 0;
        end else begin
            e_ov = 0; e_rl = 0;
            if (req_valid && !m_wait) begin
                int di, fi;
                e_core = 0; e_we = req_we;
                di = dir_find(req_addr[31:6]);
                fi = flt_find(req_addr[31:6]);
                if (req_class == 2'b00) begin
                    e_ov = 1; e_dest = 0; e_addr = req_addr; e_tag = "R2";
                end else if (req_class != 2'b10) begin
                    e_ov = 1; e_dest = 1; e_addr = req_addr; e_tag = "R3";
                end else begin
                    if (fi >= 0) flt_touch(fi);
                    if (di >= 0) begin
                        e_ov = 1; e_dest = 0; e_tag = "R4";
                        e_addr = {17'd0, d_s[di], req_addr[5:0]};
                    end else if (fi >= 0) begin
                        e_ov = 1; e_dest = 1; e_addr = req_addr; e_tag = "R5";
                    end else begin
                        e_rl = 1; e_rla = {req_addr[31:6], 6'd0};
                        m_wait = 1; m_pa = req_addr; m_pwe = req_we;
                    end
                end
            end else if (m_wait && rl_rsp_valid) begin
                m_wait = 0; e_ov = 1; e_we = m_pwe;
                if (rl_rsp_hit) begin
                    e_dest = 2; e_core = rl_rsp_core; e_tag = "R7";
                    e_addr = {17'd0, rl_rsp_spm_blk, m_pa[5:0]};
                end else begin
                    int k;
                    e_dest = 1; e_core = 0; e_addr = m_pa; e_tag = "R8";
                    k = -1;
                    for (int i = 0; i < FN; i++) if (k < 0 && !f_v[i]) k = i;
                    for (int i = 0; i < FN; i++) if (k < 0 && !f_u[i]) k = i;
                    if (k < 0) k = 0;
                    f_v[k] = 1; f_t[k] = m_pa[31:6]; flt_touch(k);
                end
            end
            if (map_valid) begin
                int w;
                w = dir_find(map_blk);
                if (w < 0) for (int i = 0; i < DN; i++) if (w < 0 && !d_v[i]) w = i;
                if (w < 0) begin w = d_rr; d_rr = (d_rr + 1) % DN; end
                d_v[w] = 1; d_t[w] = map_blk; d_s[w] = map_spm_blk;
                for (int i = 0; i < FN; i++)
                    if (f_v[i] && f_t[i] == map_blk) begin f_v[i] = 0; f_u[i] = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 ready", req_ready, !m_wait);
            chk("R6 rl_valid", rl_req_valid, e_rl);
            if (e_rl) chk("R6 rl_addr", rl_req_addr, e_rla);
            chk({e_tag, " out_valid"}, out_valid, e_ov);
            if (e_ov) begin
                chk({e_tag, " dest"}, out_dest, e_dest);
                chk({e_tag, " addr"}, out_addr, e_addr);
                chk({e_tag, " core"}, out_core, e_core);
                chk({e_tag, " we"}, out_we, e_we);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic send(logic [1:0] c, logic [31:0] a, logic we);
        @(negedge clk);
        req_valid = 1; req_class = c; req_addr = a; req_we = we;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_out(string tag, logic [1:0] d, logic [31:0] a);
        chk(tag, out_valid, 1);
        chk(tag, out_dest, d);
        chk(tag, out_addr, a);
        chk(tag, rl_req_valid, 0);
    endtask

    task automatic remote(string tag, logic [31:0] a, logic hit, logic [5:0] core, logic [8:0] sb);
        send(2'b10, a, 1'b0);
        chk("R6 request", rl_req_valid, 1);
        chk("R6 req addr", rl_req_addr, {a[31:6], 6'd0});
        chk("R6 stalled", req_ready, 0);
        rl_rsp_valid = 1; rl_rsp_hit = hit; rl_rsp_core = core; rl_rsp_spm_blk = sb;
        @(negedge clk);
        rl_rsp_valid = 0;
        chk("R6 one pulse", rl_req_valid, 0);
        chk("R6 ready back", req_ready, 1);
        chk(tag, out_valid, 1);
        chk(tag, out_dest, hit ? 2'b10 : 2'b01);
        chk(tag, out_addr, hit ? {17'd0, sb, a[5:0]} : a);
        chk(tag, out_core, hit ? core : 6'd0);
    endtask

    task automatic do_map(logic [25:0] b, logic [8:0] s);
        @(negedge clk);
        map_valid = 1; map_blk = b; map_spm_blk = s;
        @(negedge clk);
        map_valid = 0;
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1; tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 rl_req", rl_req_valid, 0);
        chk("R1 ready", req_ready, 1);

        send(2'b00, 32'h0000_1234, 1'b1);
        expect_out("R2 strided", 2'b00, 32'h0000_1234);
        chk("R2 we", out_we, 1);
        send(2'b01, 32'h8000_0010, 1'b0);
        expect_out("R3 random", 2'b01, 32'h8000_0010);
        send(2'b11, 32'h8000_0020, 1'b0);
        expect_out("R3 spare code", 2'b01, 32'h8000_0020);

        // empty tables after reset: remote miss, then filter hit
        remote("R8 remote miss", 32'h1000_0044, 1'b0, 6'd0, 9'd0);
        send(2'b10, 32'h1000_007C, 1'b1);
        expect_out("R5 filter hit", 2'b01, 32'h1000_007C);
        remote("R7 remote hit", 32'h1800_0085, 1'b1, 6'd5, 9'h012);

        // stall holds every class while a lookup is outstanding
        send(2'b10, 32'h1900_0000, 1'b0);
        req_valid = 1; req_class = 2'b00; req_addr = 32'h55;
        @(negedge clk);
        chk("R6 no accept", out_valid, 0);
        chk("R6 held", req_ready, 0);
        rl_rsp_valid = 1; rl_rsp_hit = 1; rl_rsp_core = 6'd2; rl_rsp_spm_blk = 9'h3;
        @(negedge clk);
        rl_rsp_valid = 0;
        chk("R7 after stall", out_dest, 2'b10);
        @(negedge clk);
        req_valid = 0;
        expect_out("R2 after stall", 2'b00, 32'h55);

        // mapping, remap in place, filter invalidation
        do_map(26'h040_0001, 9'h030);
        send(2'b10, 32'h1000_0048, 1'b0);
        expect_out("R4 dir hit", 2'b00, {17'd0, 9'h030, 6'h08});
        do_map(26'h040_0001, 9'h031);
        send(2'b10, 32'h1000_0041, 1'b0);
        expect_out("R9 remap", 2'b00, {17'd0, 9'h031, 6'h01});
        for (int k = 0; k < 32; k++) do_map(26'h0C0_0000 + k, 9'h040 + k);
        send(2'b10, 32'h3000_0000 + 5*64 + 4, 1'b0);
        expect_out("R11 kept entry", 2'b00, {17'd0, 9'h045, 6'h04});
        remote("R11 R9 evicted and unfiltered", 32'h1000_0040, 1'b1, 6'd3, 9'h055);

        // filter replacement
        for (int k = 0; k < 48; k++)
            remote("R8 fill", 32'h2000_0000 + k*64, 1'b0, 6'd0, 9'd0);
        send(2'b10, 32'h2000_0000, 1'b0);
        expect_out("R10 oldest retouched", 2'b01, 32'h2000_0000);
        remote("R8 overflow insert", 32'h2000_0000 + 48*64, 1'b0, 6'd0, 9'd0);
        send(2'b10, 32'h2000_0000, 1'b0);
        expect_out("R10 touched survives", 2'b01, 32'h2000_0000);
        remote("R10 victim evicted", 32'h2000_0040, 1'b1, 6'd1, 9'h007);
        send(2'b10, 32'h2000_0080, 1'b0);
        expect_out("R10 neighbour kept", 2'b01, 32'h2000_0080);

        repeat (2) @(negedge clk);
        done = 1;
        report();
    end

endmodule